// File: doc/BRIEF.md
# I2C Channel Switch Controller

This block is an I2C target that decides which downstream bus segments are joined to the upstream bus. It oversamples SCL and SDA with the system clock, recognises START and STOP, compares the 7-bit address with a parameter and acknowledges a match. In a write transfer, each data byte after the address becomes the new content of the control register. In a read transfer, the register is sent back to the host.

Each register bit maps to one downstream channel enable. A new selection is held pending and drives the enables only when a STOP closes the write transfer. This means the segments are joined only while the bus is idle. A repeated START discards the pending selection, so the enables keep their old pattern. The pass switches and the electrical side are outside the block: each connection is modelled as one enable bit. The SDA output is an open-drain pull-low request.

Top module: `chsw_top`

## Requirements
- R1: After reset, the control register and every channel enable are 0, and SDA is not pulled low. A read then returns 0x00.
- R2: The block acknowledges by pulling SDA low in the ninth clock when the received address bits 7..1 equal parameter ADDR. On a mismatch it never acknowledges, and it ignores the rest of the transfer until the next START.
- R3: Every data byte of a matched write (bit 0 low in the address byte) is acknowledged and stored in the control register. Bit i drives channel i. Bits at positions NCH and above are dropped and read back as 0.
- R4: Any combination of channels may be enabled together. No one-hot restriction applies.
- R5: The channel enables change only on the STOP that ends a write transfer. Before that STOP they keep their previous value.
- R6: When one transfer writes several bytes, only the last byte is applied at STOP.
- R7: A repeated START after a write discards the pending selection. The enables stay unchanged, including at the STOP that follows, while the control register still holds the written byte.
- R8: A matched read (bit 0 high in the address byte) returns the control register MSB first. The block sends it again for each byte the host acknowledges, and releases SDA after the host NACKs.
- R9: SDA is only ever pulled low, never driven high. The pull is switched on or off only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Upstream SCL level |
| sdaIn | input | 1 | Upstream SDA level (wired-AND bus value) |
| sdaPullLow | output | 1 | Open-drain request: 1 pulls SDA low |
| chanEn | output | NCH | Per-channel connection enables |

## Verification
The bench builds the block with ADDR = 7'h4B and NCH = 6, not with the defaults. A 6-channel build lets a written byte carry bits above the channel count, so the bench can check that bits 7 and 6 are dropped and read back as zero. The non-default address checks that the compare follows the parameter. Random command bytes and random mismatching addresses are mixed with directed runs: multi-byte writes, a repeated START straight after a write, and reads that the host acknowledges several times before its NACK.

// File: rtl/chsw_pkg.sv
package chsw_pkg;

  // Strobes and levels from control to datapath
  typedef struct packed {
    logic shiftIn;    // sample SDA into receive shifter
    logic storeCmd;   // latch received byte into control register
    logic loadTx;     // load transmit shifter from control register
    logic shiftTx;    // advance transmit shifter
    logic clearPend;  // START seen: drop pending selection
    logic applyPend;  // STOP seen: apply pending selection
    logic driveAck;   // level: acknowledge phase
    logic driveTx;    // level: read data phase
  } chswStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_IGNORE
  } chswState_t;

endpackage

// File: rtl/chsw_busSync.sv
module chsw_busSync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] sclPipe;
  logic [PIPE_W-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[PIPE_W-2:0], sclIn};
      sdaPipe <= {sdaPipe[PIPE_W-2:0], sdaIn};
    end
  end

  assign sclLvl  = sclPipe[SYNC_STAGES-1];
  assign sdaLvl  = sdaPipe[SYNC_STAGES-1];
  assign sclPrev = sclPipe[SYNC_STAGES];
  assign sdaPrev = sdaPipe[SYNC_STAGES];

  assign sclRise  = sclLvl & ~sclPrev;
  assign sclFall  = ~sclLvl & sclPrev;
  assign startDet = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopDet  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

endmodule

// File: rtl/chsw_ctrl.sv
module chsw_ctrl
  import chsw_pkg::*;
#(
  parameter logic [6:0] ADDR = 7'h70
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclRise,
  input  logic        sclFall,
  input  logic        startDet,
  input  logic        stopDet,
  input  logic        sdaLvl,
  input  logic [7:0]  rxByte,
  output chswStrobe_t stb
);

  localparam int BITS_PER_BYTE = 8;
  localparam int CNT_W = $clog2(BITS_PER_BYTE + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BITS_PER_BYTE);

  chswState_t       state;
  logic [CNT_W-1:0] bitCnt;
  logic             hostNack;
  logic             addrHit;
  logic             readDir;
  logic             byteDone;

  assign addrHit  = (rxByte[7:1] == ADDR);
  assign readDir  = rxByte[0];
  assign byteDone = sclFall && (bitCnt == LAST_BIT);

  always_comb begin
    stb           = '0;
    stb.driveAck  = (state == ST_ADDR_ACK) || (state == ST_WR_ACK);
    stb.driveTx   = (state == ST_RD);
    stb.clearPend = startDet;
    stb.applyPend = stopDet;
    stb.shiftIn   = sclRise && ((state == ST_ADDR) || (state == ST_WR));
    stb.storeCmd  = (state == ST_WR) && byteDone && !startDet && !stopDet;
    stb.loadTx    = sclFall && !startDet && !stopDet &&
                    (((state == ST_ADDR_ACK) && readDir) ||
                     ((state == ST_RD_ACK) && !hostNack));
    stb.shiftTx   = (state == ST_RD) && sclFall && (bitCnt != LAST_BIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      hostNack <= 1'b0;
    end else if (startDet) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
    end else if (stopDet) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          if (byteDone) state <= addrHit ? ST_ADDR_ACK : ST_IGNORE;
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            state  <= readDir ? ST_RD : ST_WR;
          end
        end
        ST_WR: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          if (byteDone) state <= ST_WR_ACK;
        end
        ST_WR_ACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            state  <= ST_WR;
          end
        end
        ST_RD: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          if (byteDone) state <= ST_RD_ACK;
        end
        ST_RD_ACK: begin
          if (sclRise) hostNack <= sdaLvl;
          if (sclFall) begin
            bitCnt <= '0;
            state  <= hostNack ? ST_IGNORE : ST_RD;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/chsw_datapath.sv
module chsw_datapath
  import chsw_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  chswStrobe_t    stb,
  input  logic           sdaLvl,
  output logic [7:0]     rxByte,
  output logic [NCH-1:0] ctrlReg,
  output logic [NCH-1:0] chanEn,
  output logic           sdaPullLow
);

  localparam int BYTE_W = 8;

  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-1:0] txByte;
  logic              pending;

  // Zero-extend the channel field to a full byte for reads
  for (genvar i = 0; i < BYTE_W; i++) begin : g_txByte
    if (i < NCH) begin : g_chan
      assign txByte[i] = ctrlReg[i];
    end else begin : g_pad
      assign txByte[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
    end else if (stb.shiftIn) begin
      rxShift <= {rxShift[BYTE_W-2:0], sdaLvl};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      pending <= 1'b0;
      chanEn  <= '0;
    end else begin
      if (stb.storeCmd) begin
        ctrlReg <= rxShift[NCH-1:0];
        pending <= 1'b1;
      end else if (stb.clearPend) begin
        pending <= 1'b0;
      end else if (stb.applyPend) begin
        if (pending) chanEn <= ctrlReg;
        pending <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift    <= '0;
      sdaPullLow <= 1'b0;
    end else begin
      if (stb.loadTx)       txShift <= txByte;
      else if (stb.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b0};
      sdaPullLow <= stb.driveAck | (stb.driveTx & ~txShift[BYTE_W-1]);
    end
  end

  assign rxByte = rxShift;

endmodule

// File: rtl/chsw_top.sv
module chsw_top
  import chsw_pkg::*;
#(
  parameter logic [6:0] ADDR = 7'h70,
  parameter int         NCH  = 8     // 1 to 8 channels
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           sclIn,
  input  logic           sdaIn,
  output logic           sdaPullLow,
  output logic [NCH-1:0] chanEn
);

  logic        sclLvl;
  logic        sdaLvl;
  logic        sclRise;
  logic        sclFall;
  logic        startDet;
  logic        stopDet;
  logic [7:0]  rxByte;
  logic [NCH-1:0] ctrlReg;
  chswStrobe_t stb;

  chsw_busSync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  chsw_ctrl #(.ADDR(ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaLvl(sdaLvl),
    .rxByte(rxByte), .stb(stb)
  );

  chsw_datapath #(.NCH(NCH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaLvl(sdaLvl),
    .rxByte(rxByte), .ctrlReg(ctrlReg), .chanEn(chanEn),
    .sdaPullLow(sdaPullLow)
  );

endmodule

// File: rtl/chsw_checker.sv
module chsw_checker #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rstN,
  input logic           sclLvl,
  input logic           startDet,
  input logic           stopDet,
  input logic [NCH-1:0] chanEn,
  input logic           sdaPullLow
);

  // R5: enables move only in the cycle after a STOP
  a_r5_enables_on_stop_only: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(chanEn) |-> $past(stopDet));

  // R7: a START never alters the enables
  a_r7_start_holds_enables: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> $stable(chanEn));

  // R9: the pull is switched on only while SCL is low
  a_r9_pull_on_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> (!sclLvl && !$past(sclLvl)));

  // R9: the pull is released only while SCL is low
  a_r9_pull_off_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaPullLow) |-> (!sclLvl && !$past(sclLvl)));

endmodule

bind chsw_top chsw_checker #(.NCH(NCH)) u_chk (
  .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .startDet(startDet),
  .stopDet(stopDet), .chanEn(chanEn), .sdaPullLow(sdaPullLow)
);

// File: tb/sim_chsw_top.sv
`timescale 1ns/1ps
module sim_chsw_top;

  localparam logic [6:0] ADDR = 7'h4B;
  localparam int NCH = 6;
  localparam int Q = 8;
  localparam logic [7:0] MASK = 8'((1 << NCH) - 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostScl = 1'b1;
  logic hostSdaLow = 1'b0;
  logic sdaBus;
  logic sdaPullLow;
  logic [NCH-1:0] chanEn;

  int checks = 0;
  int fails = 0;
  int pullViol = 0;
  bit done = 1'b0;
  logic prevPull = 1'b0;

  logic [7:0] expReg = 8'h00;
  logic [7:0] expEn = 8'h00;

  always #2 clk = ~clk;

  assign sdaBus = !(hostSdaLow || sdaPullLow);

  chsw_top #(.ADDR(ADDR), .NCH(NCH)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(hostScl), .sdaIn(sdaBus),
    .sdaPullLow(sdaPullLow), .chanEn(chanEn)
  );

  // R9 monitor: pull may change only while the host holds SCL low
  always @(posedge clk) begin
    if (rstN && (sdaPullLow != prevPull) && hostScl) pullViol++;
    prevPull <= sdaPullLow;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitQ(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic busStart();
    hostSdaLow = 1'b0; waitQ(1);
    hostScl = 1'b1;    waitQ(2);
    hostSdaLow = 1'b1; waitQ(2);
    hostScl = 1'b0;    waitQ(1);
  endtask

  task automatic busStop();
    hostSdaLow = 1'b1; waitQ(1);
    hostScl = 1'b1;    waitQ(2);
    hostSdaLow = 1'b0; waitQ(2);
  endtask

  task automatic writeByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      hostSdaLow = !b[i]; waitQ(1);
      hostScl = 1'b1;     waitQ(2);
      hostScl = 1'b0;     waitQ(1);
    end
    hostSdaLow = 1'b0; waitQ(1);
    hostScl = 1'b1;    waitQ(1);
    ack = !sdaBus;     waitQ(1);
    hostScl = 1'b0;    waitQ(1);
  endtask

  task automatic readByte(input bit nack, output logic [7:0] b);
    hostSdaLow = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      waitQ(1);
      hostScl = 1'b1; waitQ(1);
      b[i] = sdaBus;  waitQ(1);
      hostScl = 1'b0; waitQ(1);
    end
    hostSdaLow = !nack; waitQ(1);
    hostScl = 1'b1;     waitQ(2);
    hostScl = 1'b0;     waitQ(1);
    hostSdaLow = 1'b0;
  endtask

  // Matched write of n bytes; stop or leave the bus for a repeated START
  task automatic doWrite(input logic [7:0] data[4], input int n, input bit endStop);
    bit ack;
    busStart();
    writeByte({ADDR, 1'b0}, ack);
    check(ack, "R2 address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      writeByte(data[k], ack);
      check(ack, "R3 data ack", ack, 1);
      expReg = data[k] & MASK;
    end
    check(chanEn == expEn[NCH-1:0], "R5 enables before STOP", chanEn, expEn);
    if (endStop) begin
      busStop();
      if (n > 0) expEn = expReg;
      check(chanEn == expEn[NCH-1:0], "R5 R6 enables after STOP", chanEn, expEn);
    end
  endtask

  task automatic doRead(input int n, input bit doStart);
    bit ack;
    logic [7:0] b;
    if (doStart) busStart();
    writeByte({ADDR, 1'b1}, ack);
    check(ack, "R2 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      readByte(k == n - 1, b);
      check(b == expReg, "R8 read data", b, expReg);
    end
    check(!sdaPullLow, "R8 released after NACK", sdaPullLow, 0);
    busStop();
    check(chanEn == expEn[NCH-1:0], "R8 read leaves enables", chanEn, expEn);
  endtask

  task automatic doWrongAddr(input logic [7:0] junk);
    bit ack;
    logic [6:0] bad;
    bad = ADDR ^ 7'(1 + ($urandom % 127));
    busStart();
    writeByte({bad, 1'b0}, ack);
    check(!ack, "R2 mismatch no ack", ack, 0);
    writeByte(junk, ack);
    check(!ack, "R2 ignored byte no ack", ack, 0);
    busStop();
    check(chanEn == expEn[NCH-1:0], "R2 ignored transfer", chanEn, expEn);
  endtask

  initial begin
    logic [7:0] d[4];
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(chanEn == '0, "R1 enables after reset", chanEn, 0);
    check(!sdaPullLow, "R1 SDA released after reset", sdaPullLow, 0);
    doRead(1, 1'b1);

    // R3 R4 several channels together
    d = '{8'h15, 8'h00, 8'h00, 8'h00};
    doWrite(d, 1, 1'b1);
    check(chanEn == 6'h15, "R4 multiple channels", chanEn, 8'h15);

    // R3 upper bits dropped
    d = '{8'hFF, 8'h00, 8'h00, 8'h00};
    doWrite(d, 1, 1'b1);
    check(chanEn == 6'h3F, "R3 upper bits dropped", chanEn, 8'h3F);
    doRead(2, 1'b1);

    // R2 mismatch
    doWrongAddr(8'h00);
    doRead(1, 1'b1);

    // R6 last byte wins
    d = '{8'h01, 8'h22, 8'h0C, 8'h00};
    doWrite(d, 3, 1'b1);
    check(chanEn == 6'h0C, "R6 last byte applied", chanEn, 8'h0C);

    // R7 repeated START discards pending selection
    d = '{8'h33, 8'h00, 8'h00, 8'h00};
    doWrite(d, 1, 1'b0);
    doRead(1, 1'b1);
    check(chanEn == 6'h0C, "R7 enables unchanged after repeated START", chanEn, 8'h0C);

    // Address-only write keeps enables
    doWrite(d, 0, 1'b1);
    check(chanEn == 6'h0C, "R5 address-only write", chanEn, 8'h0C);

    // Random mix
    for (int it = 0; it < 30; it++) begin
      int op;
      op = int'($urandom % 4);
      for (int k = 0; k < 4; k++) d[k] = 8'($urandom);
      case (op)
        0: doWrite(d, 1 + int'($urandom % 3), 1'b1);
        1: begin doWrite(d, 1 + int'($urandom % 2), 1'b0); doRead(1, 1'b1); end
        2: doRead(1 + int'($urandom % 3), 1'b1);
        default: doWrongAddr(d[0]);
      endcase
    end

    check(pullViol == 0, "R9 pull changes only with SCL low", pullViol, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule